// File: doc/BRIEF.md
# Alternate-Function Pin Routing Mux

This block places each of a set of on-chip peripheral signals onto any single pad inside a fixed window of pins (pins 8 through 71 by default). Each function owns a 7-bit routing field. Zero in the field leaves the function unconnected. A value v from 1 to 64 puts the function on pin v+7. Pins outside the window can never be chosen, and field values that point past the last pin count as unconnected.

Routing fields live in 32-bit configuration words, with two functions in each word. The even-numbered function uses the low byte of the control half and the odd-numbered function uses the high byte. The upper half of each word is a per-bit write mask, so software can change one field without disturbing its neighbour. The routed result is purely combinational. Each pad's drive value and enable come from the function that selects it. Each function's input comes from the pad it selects. A per-pin owner bit from the GPIO controller can take a pad away from this block.

Top module: `pinRouteMux`

## Requirements
- R1: While reset is asserted and after it is released, every routing field is 0, every padOut and padOe bit is 0, and every funcIn bit is 0.
- R2: A function whose field holds v in 1..64 drives pin v+7: padOut and padOe of that pin follow the function's funcOut and funcOe, and the function's funcIn follows padIn of that pin.
- R3: A field of 0, or of 65..127, leaves the function unconnected: it drives no pin and its funcIn is 0.
- R4: Configuration word r holds function 2r at control bits 6:0 and function 2r+1 at control bits 14:8; a write takes effect at the clock edge that accepts it and is visible from the next cycle.
- R5: Control bit i (i in 6:0 or 14:8) changes on a write only when mask bit i+16 of the same write is 1; other control bits keep their value, and a write with all mask bits 0 changes nothing.
- R6: cfgRdData returns the addressed word with the two fields at bits 6:0 and 14:8 and bits 7, 15 and 31:16 reading 0; an index with no word reads all zeros.
- R7: When several functions select the same pin, the lowest-numbered one alone sets that pin's padOut and padOe, even when its funcOe is 0.
- R8: While gpioOwn of a pin is 1, that pin's padOut and padOe are 0 whatever selects it; the routed function still receives that pin's padIn.
- R9: A pin that no connected function selects has padOut and padOe at 0.
- R10: A write whose index is at or above the number of configuration words changes no field.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgWrIdx | input | IDX_W (3) | Configuration word index for writes |
| cfgWrData | input | 32 | Write word: mask in 31:16, control in 15:0 |
| cfgRdIdx | input | IDX_W (3) | Configuration word index for readback |
| cfgRdData | output | 32 | Readback of the addressed word (combinational) |
| funcOut | input | NUM_FUNCS (8) | Drive value from each function |
| funcOe | input | NUM_FUNCS (8) | Drive enable from each function |
| funcIn | output | NUM_FUNCS (8) | Pad value returned to each function |
| padIn | input | NUM_PINS (72) | Value seen at each pad |
| gpioOwn | input | NUM_PINS (72) | 1 = pin claimed by the GPIO controller |
| padOut | output | NUM_PINS (72) | Drive value to each pad |
| padOe | output | NUM_PINS (72) | Drive enable to each pad |

## Verification
A corrupted routing field shows up in the cycle after the write. Drive appears on the wrong pad, or the right pad goes quiet. The function's funcIn samples the wrong padIn bit. The readback of that word no longer matches the written value. A fault in the mask merge or in the index range check leaves a neighbouring field altered, and the readback and that neighbour's pad show this in the same next cycle. A fault in the priority or owner logic needs two functions on one pin, or a claimed pin, before it is visible. It then shows at once on that pin's padOut and padOe, with no register in the path.

// File: rtl/pinRouteCfgPkg.sv
`timescale 1ns/1ps
package pinRouteCfgPkg;
  localparam int CFG_W      = 32;
  localparam int FIELD_W    = 7;
  localparam int HI_LSB     = 8;
  localparam int MASK_SHIFT = 16;

  typedef logic [FIELD_W-1:0] field_t;

  // write strobes handed from control to datapath
  typedef struct packed {
    logic   wrLo;
    logic   wrHi;
    field_t loMask;
    field_t loData;
    field_t hiMask;
    field_t hiData;
  } cfgStrobe_t;

  // merge a masked write into a stored field
  function automatic field_t mergeField(input field_t old, input field_t msk, input field_t dat);
    return (old & ~msk) | (dat & msk);
  endfunction
endpackage

// File: rtl/pinRouteCtrl.sv
`timescale 1ns/1ps
module pinRouteCtrl
  import pinRouteCfgPkg::*;
#(
  parameter int NUM_REGS = 4,
  parameter int IDX_W    = 3
) (
  input  logic                cfgWrEn,
  input  logic [IDX_W-1:0]    cfgWrIdx,
  input  logic [CFG_W-1:0]    cfgWrData,
  output cfgStrobe_t          strobe,
  output logic [NUM_REGS-1:0] regSel
);
  logic idxInRange;

  assign idxInRange = ({1'b0, cfgWrIdx} < (IDX_W+1)'(NUM_REGS));

  always_comb begin
    strobe.loMask = cfgWrData[MASK_SHIFT +: FIELD_W];
    strobe.loData = cfgWrData[0 +: FIELD_W];
    strobe.hiMask = cfgWrData[MASK_SHIFT+HI_LSB +: FIELD_W];
    strobe.hiData = cfgWrData[HI_LSB +: FIELD_W];
    strobe.wrLo   = |cfgWrData[MASK_SHIFT +: FIELD_W];
    strobe.wrHi   = |cfgWrData[MASK_SHIFT+HI_LSB +: FIELD_W];
  end

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_sel
    assign regSel[r] = cfgWrEn && idxInRange && (cfgWrIdx == IDX_W'(r));
  end
endmodule

// File: rtl/pinRouteDatapath.sv
`timescale 1ns/1ps
module pinRouteDatapath
  import pinRouteCfgPkg::*;
#(
  parameter int NUM_FUNCS = 8,
  parameter int NUM_REGS  = 4,
  parameter int NUM_PINS  = 72,
  parameter int PIN_FIRST = 8,
  parameter int PIN_LAST  = 71,
  parameter int IDX_W     = 3
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  cfgStrobe_t                   strobe,
  input  logic [NUM_REGS-1:0]          regSel,
  input  logic [IDX_W-1:0]             cfgRdIdx,
  output logic [CFG_W-1:0]             cfgRdData,
  input  logic [NUM_FUNCS-1:0]         funcOut,
  input  logic [NUM_FUNCS-1:0]         funcOe,
  output logic [NUM_FUNCS-1:0]         funcIn,
  input  logic [NUM_PINS-1:0]          padIn,
  input  logic [NUM_PINS-1:0]          gpioOwn,
  output logic [NUM_PINS-1:0]          padOut,
  output logic [NUM_PINS-1:0]          padOe,
  output logic [NUM_FUNCS*FIELD_W-1:0] fieldFlat
);
  localparam int SLOTS     = 2 * NUM_REGS;
  localparam int PIN_W     = $clog2(NUM_PINS);
  localparam int FIELD_OFS = PIN_FIRST - 1;
  localparam int FIELD_MAX = PIN_LAST - FIELD_OFS;

  field_t             fieldQ   [SLOTS];
  logic [PIN_W-1:0]   fldPin   [NUM_FUNCS];
  logic [NUM_FUNCS-1:0] fldValid;

  // configuration storage, one low and one high slot per word
  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) fieldQ[2*r] <= '0;
      else if (regSel[r] && strobe.wrLo)
        fieldQ[2*r] <= mergeField(fieldQ[2*r], strobe.loMask, strobe.loData);
    end
    if (2*r+1 < NUM_FUNCS) begin : g_hi
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) fieldQ[2*r+1] <= '0;
        else if (regSel[r] && strobe.wrHi)
          fieldQ[2*r+1] <= mergeField(fieldQ[2*r+1], strobe.hiMask, strobe.hiData);
      end
    end else begin : g_noHi
      assign fieldQ[2*r+1] = '0;
    end
  end

  // field decode: pin index and validity per function
  for (genvar f = 0; f < NUM_FUNCS; f++) begin : g_dec
    assign fldValid[f] = (fieldQ[f] != '0) && (int'(fieldQ[f]) <= FIELD_MAX);
    assign fldPin[f]   = PIN_W'(int'(fieldQ[f]) + FIELD_OFS);
    assign funcIn[f]   = fldValid[f] ? padIn[fldPin[f]] : 1'b0;
    assign fieldFlat[f*FIELD_W +: FIELD_W] = fieldQ[f];
  end

  // per-pin selection, lowest function index wins
  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    logic drvOut, drvOe;
    always_comb begin
      drvOut = 1'b0;
      drvOe  = 1'b0;
      for (int f = NUM_FUNCS-1; f >= 0; f--) begin
        if (fldValid[f] && (fldPin[f] == PIN_W'(p))) begin
          drvOut = funcOut[f];
          drvOe  = funcOe[f];
        end
      end
    end
    assign padOut[p] = drvOut & ~gpioOwn[p];
    assign padOe[p]  = drvOe  & ~gpioOwn[p];
  end

  // readback of the control half
  always_comb begin
    cfgRdData = '0;
    for (int r = 0; r < NUM_REGS; r++) begin
      if (cfgRdIdx == IDX_W'(r)) begin
        cfgRdData[0 +: FIELD_W]      = fieldQ[2*r];
        cfgRdData[HI_LSB +: FIELD_W] = fieldQ[2*r+1];
      end
    end
  end
endmodule

// File: rtl/pinRouteMux.sv
`timescale 1ns/1ps
module pinRouteMux
  import pinRouteCfgPkg::*;
#(
  parameter int NUM_FUNCS = 8,
  parameter int NUM_PINS  = 72,
  parameter int PIN_FIRST = 8,
  parameter int PIN_LAST  = 71,
  localparam int NUM_REGS = (NUM_FUNCS + 1) / 2,
  localparam int IDX_W    = $clog2(NUM_REGS) + 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cfgWrEn,
  input  logic [IDX_W-1:0]     cfgWrIdx,
  input  logic [31:0]          cfgWrData,
  input  logic [IDX_W-1:0]     cfgRdIdx,
  output logic [31:0]          cfgRdData,
  input  logic [NUM_FUNCS-1:0] funcOut,
  input  logic [NUM_FUNCS-1:0] funcOe,
  output logic [NUM_FUNCS-1:0] funcIn,
  input  logic [NUM_PINS-1:0]  padIn,
  input  logic [NUM_PINS-1:0]  gpioOwn,
  output logic [NUM_PINS-1:0]  padOut,
  output logic [NUM_PINS-1:0]  padOe
);
  cfgStrobe_t                   strobe;
  logic [NUM_REGS-1:0]          regSel;
  logic [NUM_FUNCS*FIELD_W-1:0] fieldFlat;

  pinRouteCtrl #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_ctrl (
    .cfgWrEn(cfgWrEn), .cfgWrIdx(cfgWrIdx), .cfgWrData(cfgWrData),
    .strobe(strobe), .regSel(regSel)
  );

  pinRouteDatapath #(
    .NUM_FUNCS(NUM_FUNCS), .NUM_REGS(NUM_REGS), .NUM_PINS(NUM_PINS),
    .PIN_FIRST(PIN_FIRST), .PIN_LAST(PIN_LAST), .IDX_W(IDX_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .regSel(regSel),
    .cfgRdIdx(cfgRdIdx), .cfgRdData(cfgRdData),
    .funcOut(funcOut), .funcOe(funcOe), .funcIn(funcIn),
    .padIn(padIn), .gpioOwn(gpioOwn), .padOut(padOut), .padOe(padOe),
    .fieldFlat(fieldFlat)
  );
endmodule

// File: rtl/pinRouteMuxChk.sv
`timescale 1ns/1ps
module pinRouteMuxChk #(
  parameter int NUM_FUNCS = 8,
  parameter int NUM_PINS  = 72,
  parameter int NUM_REGS  = 4,
  parameter int IDX_W     = 3
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   cfgWrEn,
  input logic [IDX_W-1:0]       cfgWrIdx,
  input logic [31:0]            cfgWrData,
  input logic [31:0]            cfgRdData,
  input logic [NUM_FUNCS-1:0]   funcIn,
  input logic [NUM_PINS-1:0]    gpioOwn,
  input logic [NUM_PINS-1:0]    padOut,
  input logic [NUM_PINS-1:0]    padOe,
  input logic [NUM_FUNCS*7-1:0] fieldFlat
);
  function automatic logic [6:0] fieldOf(input logic [NUM_FUNCS*7-1:0] flat, input int f);
    return flat[f*7 +: 7];
  endfunction

  // R1
  always @(posedge clk) begin
    if (!rstN) r1_reset_quiet_chk: assert (padOe == '0 && padOut == '0 && funcIn == '0 && fieldFlat == '0);
  end

  // R4
  r4_lo_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWrEn && ({1'b0, cfgWrIdx} < (IDX_W+1)'(NUM_REGS)) && cfgWrData[22:16] == 7'h7F)
    |=> fieldOf(fieldFlat, 2*int'($past(cfgWrIdx))) == $past(cfgWrData[6:0]));

  // R5
  r5_mask_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWrEn && cfgWrData[31:16] == 16'h0) |=> $stable(fieldFlat));

  // R6
  r6_rd_zero_bits_chk: assert property (@(posedge clk) disable iff (!rstN)
    cfgRdData[31:16] == 16'h0 && !cfgRdData[15] && !cfgRdData[7]);

  // R8
  r8_owner_block_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((padOe | padOut) & gpioOwn) == '0);

  // R10
  r10_range_ignore_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWrEn && ({1'b0, cfgWrIdx} >= (IDX_W+1)'(NUM_REGS))) |=> $stable(fieldFlat));
endmodule

bind pinRouteMux pinRouteMuxChk #(
  .NUM_FUNCS(NUM_FUNCS), .NUM_PINS(NUM_PINS), .NUM_REGS(NUM_REGS), .IDX_W(IDX_W)
) u_chk (
  .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgWrIdx(cfgWrIdx),
  .cfgWrData(cfgWrData), .cfgRdData(cfgRdData), .funcIn(funcIn),
  .gpioOwn(gpioOwn), .padOut(padOut), .padOe(padOe), .fieldFlat(fieldFlat)
);

// File: tb/pinRouteMux_tb.sv
`timescale 1ns/1ps
module pinRouteMux_tb;
  localparam int NF = 8;
  localparam int NP = 72;
  localparam int NR = 4;

  logic clk = 1'b0, rstN = 1'b0;
  logic cfgWrEn = 1'b0;
  logic [2:0] cfgWrIdx = '0, cfgRdIdx = '0;
  logic [31:0] cfgWrData = '0, cfgRdData;
  logic [NF-1:0] funcOut = '0, funcOe = '0, funcIn;
  logic [NP-1:0] padIn = '0, gpioOwn = '0, padOut, padOe;

  int nChk = 0, nBad = 0;
  bit running = 0, done = 0;
  string curReq = "R1";
  logic [6:0] mFld [NF];

  always #10 clk = ~clk;

  pinRouteMux u_dut (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgWrIdx(cfgWrIdx),
    .cfgWrData(cfgWrData), .cfgRdIdx(cfgRdIdx), .cfgRdData(cfgRdData),
    .funcOut(funcOut), .funcOe(funcOe), .funcIn(funcIn),
    .padIn(padIn), .gpioOwn(gpioOwn), .padOut(padOut), .padOe(padOe)
  );

  task automatic chk(input string req, input string what, input logic [127:0] act, input logic [127:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic bit isMapped(input int f);
    return mFld[f] != 0 && mFld[f] <= 64;
  endfunction

  // behavioural expectation from the stored fields and present inputs
  task automatic expect_all(output logic [NP-1:0] eOut, output logic [NP-1:0] eOe,
                            output logic [NF-1:0] eIn, output logic [31:0] eRd);
    eOut = '0; eOe = '0; eIn = '0; eRd = '0;
    for (int p = 0; p < NP; p++) begin
      if (!gpioOwn[p]) begin
        for (int f = 0; f < NF; f++) begin
          if (isMapped(f) && int'(mFld[f]) + 7 == p) begin
            eOut[p] = funcOut[f];
            eOe[p]  = funcOe[f];
            break;
          end
        end
      end
    end
    for (int f = 0; f < NF; f++)
      if (isMapped(f)) eIn[f] = padIn[int'(mFld[f]) + 7];
    if (int'(cfgRdIdx) < NR) eRd = {16'h0, 1'b0, mFld[2*cfgRdIdx+1], 1'b0, mFld[2*cfgRdIdx]};
  endtask

  // per-cycle comparison against the model
  always begin
    logic [NP-1:0] eOut, eOe;
    logic [NF-1:0] eIn;
    logic [31:0] eRd;
    @(negedge clk);
    #4;
    if (running) begin
      expect_all(eOut, eOe, eIn, eRd);
      chk(curReq, "padOut", 128'(padOut), 128'(eOut));
      chk(curReq, "padOe", 128'(padOe), 128'(eOe));
      chk(curReq, "funcIn", 128'(funcIn), 128'(eIn));
      chk(curReq, "cfgRdData", 128'(cfgRdData), 128'(eRd));
    end
  end

  task automatic settle();
    @(negedge clk);
    #5;
  endtask

  task automatic wrCfg(input logic [2:0] idx, input logic [31:0] data);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgWrIdx = idx; cfgWrData = data;
    @(posedge clk);
    if (int'(idx) < NR) begin
      for (int b = 0; b < 7; b++) begin
        if (data[16+b]) mFld[2*idx][b] = data[b];
        if (data[24+b]) mFld[2*idx+1][b] = data[8+b];
      end
    end
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nChk++; nBad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end

  initial begin
    for (int f = 0; f < NF; f++) mFld[f] = '0;
    funcOut = 8'b1010_0110; funcOe = 8'hFF;
    repeat (3) @(posedge clk);
    // R1 outputs quiet during reset
    #5;
    chk("R1", "padOe in reset", 128'(padOe), 128'(0));
    chk("R1", "funcIn in reset", 128'(funcIn), 128'(0));
    @(negedge clk); rstN = 1'b1;
    running = 1;
    settle();
    chk("R1", "padOut after reset", 128'(padOut), 128'(0));
    chk("R1", "rd word0 after reset", 128'(cfgRdData), 128'(0));

    // R2 f0 -> pin 8, f1 -> pin 71
    curReq = "R2";
    padIn = '0; padIn[71] = 1'b1;
    wrCfg(3'd0, 32'h7F7F_4001);
    settle();
    chk("R2", "padOe[8]", 128'(padOe[8]), 128'(1));
    chk("R2", "padOut[71]", 128'(padOut[71]), 128'(1));
    chk("R2", "funcIn[1] from pin71", 128'(funcIn[1]), 128'(1));
    funcOut[0] = 1'b1;
    settle();
    chk("R2", "padOut[8] follows funcOut[0]", 128'(padOut[8]), 128'(1));

    // R4 word 3 holds f6 low, f7 high
    curReq = "R4";
    cfgRdIdx = 3'd3;
    wrCfg(3'd3, 32'h7F7F_0A05);
    settle();
    chk("R4", "rd word3", 128'(cfgRdData), 128'(32'h0000_0A05));
    chk("R4", "padOut[17] from f7", 128'(padOut[17]), 128'(1));

    // R5 partial mask and empty mask
    curReq = "R5";
    wrCfg(3'd3, 32'h0002_7F7F);
    settle();
    chk("R5", "rd word3 one bit", 128'(cfgRdData), 128'(32'h0000_0A07));
    wrCfg(3'd3, 32'h0000_1234);
    settle();
    chk("R5", "rd word3 empty mask", 128'(cfgRdData), 128'(32'h0000_0A07));

    // R3 f2=65, f3=127 unconnected
    curReq = "R3";
    padIn = '1;
    wrCfg(3'd1, 32'h7F7F_7F41);
    settle();
    chk("R3", "funcIn f2 f3", 128'(funcIn[3:2]), 128'(0));
    begin
      logic [NP-1:0] e;
      e = '0; e[8] = 1'b1; e[71] = 1'b1; e[14] = 1'b1; e[17] = 1'b1;
      chk("R3", "padOe set", 128'(padOe), 128'(e));
    end

    // R7 f1 and f4 both on pin 20
    curReq = "R7";
    padIn = '0; padIn[20] = 1'b1;
    wrCfg(3'd0, 32'h7F00_0D00);
    wrCfg(3'd2, 32'h007F_000D);
    funcOut[4] = 1'b0;
    settle();
    chk("R7", "padOut[20] from f1", 128'(padOut[20]), 128'(1));
    funcOe[1] = 1'b0; funcOe[4] = 1'b1;
    settle();
    chk("R7", "padOe[20] lower index wins", 128'(padOe[20]), 128'(0));
    chk("R7", "funcIn f1 f4", 128'({funcIn[4], funcIn[1]}), 128'(2'b11));

    // R9 pin 71 left behind
    curReq = "R9";
    chk("R9", "padOe[71] released", 128'(padOe[71]), 128'(0));
    chk("R9", "padOut[71] released", 128'(padOut[71]), 128'(0));

    // R8 owner claims pin 20
    curReq = "R8";
    funcOe[1] = 1'b1;
    gpioOwn[20] = 1'b1;
    settle();
    chk("R8", "padOe[20] claimed", 128'(padOe[20]), 128'(0));
    chk("R8", "padOut[20] claimed", 128'(padOut[20]), 128'(0));
    chk("R8", "funcIn[4] still sees pad", 128'(funcIn[4]), 128'(1));
    gpioOwn[20] = 1'b0;

    // R10 write beyond the last word
    curReq = "R10";
    cfgRdIdx = 3'd0;
    wrCfg(3'd5, 32'h7F7F_0101);
    settle();
    chk("R10", "rd word0 untouched", 128'(cfgRdData), 128'(32'h0000_0D01));
    chk("R10", "padOe[8] untouched", 128'(padOe[8]), 128'(1));

    // R6 readback zero bits and empty index
    curReq = "R6";
    cfgRdIdx = 3'd2;
    wrCfg(3'd2, 32'hFFFF_8D8D);
    settle();
    chk("R6", "rd word2", 128'(cfgRdData), 128'(32'h0000_0D0D));
    cfgRdIdx = 3'd6;
    settle();
    chk("R6", "rd empty index", 128'(cfgRdData), 128'(0));

    repeat (4) @(negedge clk);
    running = 0;
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule